// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a byte, word or doubleword access to an I/O port may go ahead once the surrounding pipeline has already found that the privilege comparison calls for a bitmap lookup. On a request strobe it captures the port number, the access-width mask and the current task segment's base and limit. It then fetches a 16-bit bitmap pointer stored inside the task segment. After a limit check it fetches the single bitmap byte that holds the port's permission bits. It answers with a one-cycle completion pulse that carries either an allow or a general-protection fault (error code zero).

Both memory fetches go through a simple request/valid read port. Each fetch is flagged as a supervisor-level read, so the lookup works no matter what privilege the code that issued the I/O instruction runs at. Only one read is outstanding at a time. The block holds the request and its address until the response arrives. The caller is expected to keep an access inside one bitmap byte. When an access runs past bit 7 of the fetched byte, the missing bits count as clear.

Top module: `io_perm_check`

## Requirements
- R1: While reset is held and in the first cycle after it, done, allow, gp_fault and mem_rd_req are all low.
- R2: After an accepted request, the first read is a 16-bit read (mem_rd_word high) at tss_base + 0x66, and mem_rd_pl0 is high on it.
- R3: Let idx = pointer + (port >> 3). When idx is strictly greater than tss_limit, the result is gp_fault and no bitmap byte is read. When idx equals tss_limit, the byte is read.
- R4: The bitmap read is an 8-bit read (mem_rd_word low) at tss_base + idx, with mem_rd_pl0 high. The byte is taken from mem_rd_data[7:0].
- R5: The fetched byte is shifted right by port[2:0] and ANDed with the mask (4'b0001 byte, 4'b0011 word, 4'b1111 doubleword). Any set result bit gives gp_fault.
- R6: When that AND is zero, the result is allow.
- R7: Only the one fetched byte is consulted. Mask bits that fall beyond its bit 7 see a clear permission bit, so they never deny.
- R8: done is a single-cycle pulse, and exactly one of allow and gp_fault is high with it. Both are low whenever done is low.
- R9: A req_valid that arrives while a check is in progress is ignored. The result reflects the inputs captured when the request was accepted.
- R10: mem_rd_req stays high with a stable mem_rd_addr until mem_rd_valid arrives. A mem_rd_valid that arrives while no read is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a check; taken only when idle |
| req_port | input | 16 | I/O port number |
| req_mask | input | 4 | Access-width mask (0001, 0011, 1111) |
| tss_base | input | 32 | Linear base of the current task segment |
| tss_limit | input | 32 | Limit of the current task segment |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_word | output | 1 | High for a 16-bit read, low for an 8-bit read |
| mem_rd_pl0 | output | 1 | Read is performed at privilege level 0 |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data |
| done | output | 1 | One-cycle result pulse |
| allow | output | 1 | Access permitted (with done) |
| gp_fault | output | 1 | General-protection fault, error code 0 (with done) |

## Verification
Random ports, masks, pointers and task bases are mixed with limits placed just below, at and above the computed byte index, so the strict-greater comparison and the skipped byte read are told apart from an off-by-one. Directed bitmap bytes separate the three mask widths. One of them, 0x02, denies a word access but not a byte access at the same port. Others put a port at bit position 7, where a doubleword mask would reach past the byte. Stray responses while idle, and a second strobe during a check, show that the captured request alone decides the result. Random read latencies exercise the held request.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_PTR = 2'd1,
        ST_RD_MAP = 2'd2,
        ST_DONE   = 2'd3
    } ioperm_state_e;

endpackage

// File: rtl/io_perm_locate.sv
// Address generation and segment-limit test for the bitmap lookup.
module io_perm_locate #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned IDX_W   = 13,
    parameter int unsigned PTR_LOC = 'h66
) (
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [OFS_W-1:0]  map_ptr,
    input  logic [IDX_W-1:0]  byte_idx,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] map_addr,
    output logic              beyond_limit
);
    localparam int unsigned PTR_PAD = ADDR_W - OFS_W;
    localparam int unsigned IDX_PAD = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] rel_idx;

    // Pointer and port byte index are both far narrower than the address,
    // so their sum cannot wrap.
    assign rel_idx      = {{PTR_PAD{1'b0}}, map_ptr} + {{IDX_PAD{1'b0}}, byte_idx};
    assign beyond_limit = rel_idx > seg_limit;
    assign ptr_addr     = seg_base + ADDR_W'(PTR_LOC);
    assign map_addr     = seg_base + rel_idx;

endmodule

// File: rtl/io_perm_judge.sv
// Picks the permission bits covered by the access out of one bitmap byte.
module io_perm_judge #(
    parameter int unsigned MASK_W = 4
) (
    input  logic [7:0]        map_byte,
    input  logic [2:0]        bit_sel,
    input  logic [MASK_W-1:0] acc_mask,
    output logic              deny
);
    logic [MASK_W-1:0] hit;

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        logic [3:0] pos;
        assign pos    = {1'b0, bit_sel} + 4'(i);
        // Positions past bit 7 lie in the next byte, which is not fetched.
        assign hit[i] = acc_mask[i] & (pos < 4'd8) & map_byte[pos[2:0]];
    end

    assign deny = |hit;

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned PORT_W  = 16,
    parameter int unsigned MASK_W  = 4,
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned PTR_LOC = 'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [ADDR_W-1:0] tss_base,
    input  logic [ADDR_W-1:0] tss_limit,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_rd_word,
    output logic              mem_rd_pl0,
    input  logic              mem_rd_valid,
    input  logic [OFS_W-1:0]  mem_rd_data,
    output logic              done,
    output logic              allow,
    output logic              gp_fault
);
    import io_perm_pkg::*;

    localparam int unsigned IDX_W = PORT_W - 3;

    typedef struct packed {
        ioperm_state_e     state;
        logic [PORT_W-1:0] port;
        logic [MASK_W-1:0] mask;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [OFS_W-1:0]  ptr;
        logic              deny;
    } chk_regs_t;

    chk_regs_t r_d, r_q;

    logic [OFS_W-1:0]  ptr_sel;
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] map_addr;
    logic              beyond_limit;
    logic              byte_deny;

    // While the pointer arrives the limit test uses it straight from the bus.
    assign ptr_sel = (r_q.state == ST_RD_PTR) ? mem_rd_data : r_q.ptr;

    io_perm_locate #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W),
        .PTR_LOC(PTR_LOC)
    ) u_locate (
        .seg_base    (r_q.base),
        .seg_limit   (r_q.limit),
        .map_ptr     (ptr_sel),
        .byte_idx    (r_q.port[PORT_W-1:3]),
        .ptr_addr    (ptr_addr),
        .map_addr    (map_addr),
        .beyond_limit(beyond_limit)
    );

    io_perm_judge #(
        .MASK_W(MASK_W)
    ) u_judge (
        .map_byte(mem_rd_data[7:0]),
        .bit_sel (r_q.port[2:0]),
        .acc_mask(r_q.mask),
        .deny    (byte_deny)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.port  = req_port;
                    r_d.mask  = req_mask;
                    r_d.base  = tss_base;
                    r_d.limit = tss_limit;
                    r_d.deny  = 1'b0;
                    r_d.state = ST_RD_PTR;
                end
            end
            ST_RD_PTR: begin
                if (mem_rd_valid) begin
                    r_d.ptr = mem_rd_data;
                    if (beyond_limit) begin
                        r_d.deny  = 1'b1;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_RD_MAP;
                    end
                end
            end
            ST_RD_MAP: begin
                if (mem_rd_valid) begin
                    r_d.deny  = byte_deny;
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_req  = (r_q.state == ST_RD_PTR) || (r_q.state == ST_RD_MAP);
    assign mem_rd_word = (r_q.state == ST_RD_PTR);
    assign mem_rd_addr = (r_q.state == ST_RD_PTR) ? ptr_addr : map_addr;
    assign mem_rd_pl0  = mem_rd_req;
    assign done        = (r_q.state == ST_DONE);
    assign allow       = done & ~r_q.deny;
    assign gp_fault    = done & r_q.deny;

endmodule

// File: rtl/io_perm_check_sva.sv
module io_perm_check_sva #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_word,
    input logic              mem_rd_valid,
    input logic              done,
    input logic              allow,
    input logic              gp_fault
);
    // R8
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({allow, gp_fault}));

    // R8
    quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !allow && !gp_fault);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr) && $stable(mem_rd_word));

    // R2
    first_read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> mem_rd_word);

    // R10
    no_read_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_req);

endmodule

bind io_perm_check io_perm_check_sva #(
    .ADDR_W(ADDR_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_word (mem_rd_word),
    .mem_rd_valid(mem_rd_valid),
    .done        (done),
    .allow       (allow),
    .gp_fault    (gp_fault)
);

// File: tb/io_perm_check_tb.sv
`timescale 1ns/1ps
module io_perm_check_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_port = '0;
    logic [3:0]  req_mask = '0;
    logic [31:0] tss_base = '0;
    logic [31:0] tss_limit = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_word;
    logic        mem_rd_pl0;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        done;
    logic        allow;
    logic        gp_fault;

    int n_checks = 0;
    int n_fail   = 0;

    // memory model controls and observations
    logic [15:0] tb_ptr = '0;
    logic        ovr_en = 1'b0;
    logic [7:0]  ovr_byte = '0;
    logic        inject = 1'b0;
    int          word_reads = 0;
    int          map_reads = 0;
    int          pl0_bad = 0;
    logic [31:0] last_ptr_addr = '0;
    logic [31:0] last_map_addr = '0;

    io_perm_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_mask(req_mask), .tss_base(tss_base), .tss_limit(tss_limit),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_word(mem_rd_word),
        .mem_rd_pl0(mem_rd_pl0), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .allow(allow), .gp_fault(gp_fault)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic [7:0] model_byte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] served_byte(input logic [31:0] a);
        return ovr_en ? ovr_byte : model_byte(a);
    endfunction

    // read responder: random latency, one-cycle valid pulses
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
            end else if (inject && !mem_rd_req) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = 16'hFFFF;
                inject       = 1'b0;
            end else if (mem_rd_req) begin
                if (wait_cnt == 0) begin
                    if (!mem_rd_pl0) pl0_bad++;
                    if (mem_rd_word) begin
                        word_reads++;
                        last_ptr_addr = mem_rd_addr;
                        mem_rd_data   = tb_ptr;
                    end else begin
                        map_reads++;
                        last_map_addr = mem_rd_addr;
                        mem_rd_data   = {8'h5C, served_byte(mem_rd_addr)};
                    end
                    mem_rd_valid = 1'b1;
                    wait_cnt = int'($urandom % 4);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [15:0] port, input logic [3:0] mask,
                            input logic [31:0] base, input logic [31:0] limit,
                            input logic [15:0] ptr, input bit poke);
        logic [31:0] idx;
        logic        beyond;
        logic        exp_fault;
        logic [7:0]  b;
        int          guard;
        idx    = 32'(ptr) + 32'(port[15:3]);
        beyond = idx > limit;
        b      = served_byte(base + idx);
        exp_fault = beyond || ((({8'h00, b} >> port[2:0]) & {12'h000, mask}) != 16'h0);
        @(negedge clk);
        tb_ptr = ptr; req_port = port; req_mask = mask; tss_base = base; tss_limit = limit;
        word_reads = 0; map_reads = 0; pl0_bad = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_port = ~port; req_mask = 4'hF; tss_limit = 32'hFFFF_FFFF; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(done, "R8 done seen", 32'(done), 32'd1);
        chk(gp_fault == exp_fault, poke ? "R9 busy request ignored" :
            (beyond ? "R3 limit fault" : "R5/R6 bitmap verdict"), 32'(gp_fault), 32'(exp_fault));
        chk(allow == !exp_fault, "R6 allow", 32'(allow), 32'(!exp_fault));
        chk(word_reads == 1 && last_ptr_addr == base + 32'h66, "R2 pointer read",
            last_ptr_addr, base + 32'h66);
        chk(pl0_bad == 0, "R2 R4 pl0 flag", 32'(pl0_bad), 32'd0);
        chk(map_reads == (beyond ? 0 : 1), "R3 byte read count", 32'(map_reads), beyond ? 32'd0 : 32'd1);
        if (!beyond)
            chk(last_map_addr == base + idx, "R4 byte address", last_map_addr, base + idx);
        @(negedge clk);
        chk(!done && !allow && !gp_fault, "R8 single pulse",
            {29'd0, done, allow, gp_fault}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] masks [3];
        masks[0] = 4'b0001; masks[1] = 4'b0011; masks[2] = 4'b1111;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!done && !allow && !gp_fault && !mem_rd_req, "R1 in reset",
            {28'd0, done, allow, gp_fault, mem_rd_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !allow && !gp_fault && !mem_rd_req, "R1 after reset",
            {28'd0, done, allow, gp_fault, mem_rd_req}, 32'd0);

        // R10: stray response while idle does nothing
        inject = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!done && !mem_rd_req, "R10 stray valid ignored", {30'd0, done, mem_rd_req}, 32'd0);

        // directed bitmap bytes
        ovr_en = 1'b1;
        ovr_byte = 8'h00; run_case(16'h03F8, 4'b1111, 32'h0001_0000, 32'hFFFF, 16'h0100, 0); // R6
        ovr_byte = 8'h02; run_case(16'h0040, 4'b0001, 32'h0002_0000, 32'hFFFF, 16'h0080, 0); // R6 byte ok
        ovr_byte = 8'h02; run_case(16'h0040, 4'b0011, 32'h0002_0000, 32'hFFFF, 16'h0080, 0); // R5 word denied
        ovr_byte = 8'h80; run_case(16'h0017, 4'b0001, 32'h0003_0000, 32'hFFFF, 16'h0080, 0); // R5 bit 7
        ovr_byte = 8'h7F; run_case(16'h0017, 4'b1111, 32'h0003_0000, 32'hFFFF, 16'h0080, 0); // R7 spill clear
        ovr_byte = 8'h10; run_case(16'h0021, 4'b1111, 32'h0004_0000, 32'hFFFF, 16'h0088, 0); // R5 dword
        // R3: idx equal to limit reads, one above faults
        ovr_byte = 8'h00; run_case(16'h0080, 4'b0001, 32'h0005_0000, 32'h0000_0110, 16'h0100, 0);
        ovr_byte = 8'h00; run_case(16'h0080, 4'b0001, 32'h0005_0000, 32'h0000_010F, 16'h0100, 0);
        // R9: second strobe during a check
        ovr_byte = 8'h01; run_case(16'h0008, 4'b0001, 32'h0006_0000, 32'hFFFF, 16'h0040, 1);
        ovr_en = 1'b0;

        // random cases
        for (int k = 0; k < 80; k++) begin
            logic [15:0] p;
            logic [15:0] o;
            logic [31:0] bs;
            logic [31:0] lim;
            logic [31:0] ix;
            p  = 16'($urandom);
            o  = 16'($urandom);
            bs = $urandom & 32'hFFFF_FF00;
            ix = 32'(o) + 32'(p[15:3]);
            case ($urandom % 3)
                0: lim = ix + 32'($urandom % 3);
                1: lim = (ix > 2) ? ix - 32'($urandom % 3) : ix;
                default: lim = $urandom;
            endcase
            run_case(p, masks[$urandom % 3], bs, lim, o, ($urandom % 8) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule